// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two 32-bit unsigned operands and returns a 64-bit unsigned product. It does this by conditional add and right shift over many clock cycles instead of a single-cycle array. A start pulse loads a 64-bit working register: the multiplier goes into the lower half and the upper half is cleared. The block then examines one multiplier bit per clock. When that bit is 1, the multiplicand is added into the upper half. In every iteration the register shifts right by one place, and the carry out of the add enters at the top. After 32 iterations the register holds the product.

The accumulate adder is a separate internal block, and a parameter picks its architecture at elaboration. One option is a carry-lookahead adder built from per-bit propagate (XOR) and generate (AND) terms, grouped so that carries cross groups by group propagate/generate. The other option is a chain of full adders with a ripple carry. Both adders start from a carry-in of zero and must return identical results. The choice only changes the depth of the critical path.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` and `done_o` are 0 and `prod_o` is 0 until a start is accepted.
- R2: A start is accepted when `start_i` is 1 at a rising clock edge while `busy_o` is 0. `busy_o` is 1 from the following cycle for exactly 32 cycles.
- R3: `done_o` is a single-cycle pulse. It rises 32 cycles after the accepting edge, so the result appears 33 edges after start counting that edge. `busy_o` is 0 in the done cycle.
- R4: In the done cycle `prod_o` equals the unsigned product of the multiplicand and the multiplier that were presented with the accepted start.
- R5: The carry out of each 32-bit accumulate enters bit 63 during the same shift. For example, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R6: If either operand is zero, the product is zero.
- R7: A start request while `busy_o` is 1 is ignored. The running product and its done timing are unchanged.
- R8: `prod_o` holds its value from the done cycle until the next accepted start.
- R9: The lookahead adder variant (`ADDER` = ADD_LOOKAHEAD, encoding 0) and the ripple variant (ADD_RIPPLE, encoding 1) produce identical products and timing.
- R10: A start presented in the done cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to begin a multiplication with the operands below |
| mcand_i | input | 32 | Multiplicand, unsigned |
| mplier_i | input | 32 | Multiplier, unsigned |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse: product is complete |
| prod_o | output | 64 | 64-bit working register, holds the product after done |

## Verification
The hardest case to reach is a carry out of the accumulate that must land in bit 63. It only occurs when both the partial sum in the upper half and the multiplicand are large. Random operands rarely produce it in late iterations. The stimulus therefore mixes directed all-ones and near-all-ones operands with random values. A second start is also injected in the middle of a run, and another start is placed in the done cycle itself, to exercise the acceptance window.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

  typedef enum logic {
    ADD_LOOKAHEAD = 1'b0,
    ADD_RIPPLE    = 1'b1
  } adder_kind_e;

endpackage

// File: rtl/sam_add_lookahead.sv
// Carry-lookahead adder: bit propagate/generate, grouped carries.
module sam_add_lookahead #(
  parameter int W     = 32,
  parameter int GROUP = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NG = W / GROUP;

  logic [W-1:0]  p, g;
  logic [NG-1:0] gp, gg;

  assign p = a_i ^ b_i;
  assign g = a_i & b_i;

  // group propagate / generate
  always_comb begin
    for (int k = 0; k < NG; k++) begin
      logic pp, gacc;
      pp   = 1'b1;
      gacc = 1'b0;
      for (int j = 0; j < GROUP; j++) begin
        gacc = g[k*GROUP+j] | (p[k*GROUP+j] & gacc);
        pp   = pp & p[k*GROUP+j];
      end
      gp[k] = pp;
      gg[k] = gacc;
    end
  end

  // carries across groups, then inside each group
  always_comb begin
    logic cg;
    logic cb;
    cg    = 1'b0;
    sum_o = '0;
    for (int k = 0; k < NG; k++) begin
      cb = cg;
      for (int j = 0; j < GROUP; j++) begin
        sum_o[k*GROUP+j] = p[k*GROUP+j] ^ cb;
        cb = g[k*GROUP+j] | (p[k*GROUP+j] & cb);
      end
      cg = gg[k] | (gp[k] & cg);
    end
    cout_o = cg;
  end

endmodule

// File: rtl/sam_add_ripple.sv
// Ripple-carry adder: chain of full adders from carry-in 0.
module sam_add_ripple #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  always_comb begin
    logic cy;
    cy    = 1'b0;
    sum_o = '0;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = a_i[i] ^ b_i[i] ^ cy;
      cy = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & cy);
    end
    cout_o = cy;
  end
endmodule

// File: rtl/sam_adder.sv
module sam_adder
  import shiftadd_mul_pkg::*;
#(
  parameter int          W     = 32,
  parameter int          GROUP = 4,
  parameter adder_kind_e KIND  = ADD_LOOKAHEAD
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  generate
    if (KIND == ADD_LOOKAHEAD) begin : g_cla
      sam_add_lookahead #(.W(W), .GROUP(GROUP)) u_add (
        .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .cout_o(cout_o)
      );
    end else begin : g_rca
      sam_add_ripple #(.W(W)) u_add (
        .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .cout_o(cout_o)
      );
    end
  endgenerate
endmodule

// File: rtl/sam_ctrl.sv
// Iteration counter and run/done control.
module sam_ctrl #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign cnt_en = load_o | busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shiftadd_mul_pkg::*;
#(
  parameter int          W     = 32,
  parameter int          GROUP = 4,
  parameter adder_kind_e ADDER = ADD_LOOKAHEAD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic          load, step;
  logic [PW-1:0] acc_q, acc_d;
  logic [W-1:0]  mcand_q;
  logic [W-1:0]  sum;
  logic          cout;
  logic          acc_en;

  sam_ctrl #(.N(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .step_o(step), .busy_o(busy_o), .done_o(done_o)
  );

  sam_adder #(.W(W), .GROUP(GROUP), .KIND(ADDER)) u_add (
    .a_i(acc_q[PW-1:W]), .b_i(mcand_q), .sum_o(sum), .cout_o(cout)
  );

  assign acc_en = load | step;

  always_comb begin
    acc_d = acc_q;
    if (load) begin
      acc_d = {{W{1'b0}}, mplier_i};
    end else if (step) begin
      if (acc_q[0]) acc_d = {cout, sum, acc_q[W-1:1]};
      else          acc_d = {1'b0, acc_q[PW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else begin
      if (acc_en) acc_q   <= acc_d;
      if (load)   mcand_q <= mcand_i;
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] prod_o
);
  localparam int RW = $clog2(W + 1) + 1;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o)            run_cnt <= run_cnt + 1'b1;
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == RW'(W)));

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_cnt < RW'(W - 1)) |=> busy_o);

  a_r8_prod_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
);

// File: tb/test_shiftadd_mul.sv
module test_shiftadd_mul;
  import shiftadd_mul_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mcand = '0, mplier = '0;
  logic        busy_a, done_a, busy_b, done_b;
  logic [63:0] prod_a, prod_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shiftadd_mul #(.ADDER(ADD_LOOKAHEAD)) i_shiftadd_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(mcand),
    .mplier_i(mplier), .busy_o(busy_a), .done_o(done_a), .prod_o(prod_a)
  );

  shiftadd_mul #(.ADDER(ADD_RIPPLE)) i_shiftadd_mul_rca (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(mcand),
    .mplier_i(mplier), .busy_o(busy_b), .done_o(done_b), .prod_o(prod_b)
  );

  function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b);
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Run one operation. b2b: already at the negedge of a done cycle.
  task automatic op(logic [31:0] a, logic [31:0] b, bit inject, bit b2b, string req);
    logic [63:0] exp;
    exp = ref_mul(a, b);
    if (!b2b) @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0; mcand = ~a; mplier = ~b;
    chk(busy_a && busy_b, "R2 busy after start", {busy_a, busy_b}, 2'b11);
    for (int k = 1; k < 32; k++) begin
      if (inject && k == 5) start = 1'b1;
      if (inject && k == 6) start = 1'b0;
      @(negedge clk);
      if (!(busy_a && busy_b && !done_a && !done_b))
        chk(1'b0, inject ? "R7 busy during run" : "R2 busy during run",
            {busy_a, busy_b, done_a, done_b}, 4'b1100);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done_a && done_b && !busy_a && !busy_b, "R3 done pulse timing",
        {busy_a, busy_b, done_a, done_b}, 4'b0011);
    chk(prod_a == exp, req, prod_a, exp);
    chk(prod_b == prod_a, "R9 ripple equals lookahead", prod_b, prod_a);
  endtask

  initial begin
    int unsigned seed;
    logic [63:0] held;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(!busy_a && !done_a && prod_a == 0, "R1 reset state", prod_a, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_b && !done_b && prod_b == 0, "R1 after release", prod_b, 64'd0);

    op(32'd6, 32'd7, 1'b0, 1'b0, "R4 small product");
    @(negedge clk);
    chk(!done_a && !done_b, "R3 done lasts one cycle", {done_a, done_b}, 2'b00);
    held = prod_a;
    repeat (4) @(negedge clk);
    chk(prod_a == held && prod_b == held, "R8 product held", prod_a, held);

    op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, "R5 all ones");
    op(32'h0, 32'hDEADBEEF, 1'b0, 1'b0, "R6 zero multiplicand");
    op(32'h89ABCDEF, 32'h0, 1'b0, 1'b0, "R6 zero multiplier");
    op(32'hFFFFFFFF, 32'h80000001, 1'b0, 1'b0, "R5 carry into top");
    op(32'h12345678, 32'h9ABCDEF0, 1'b1, 1'b0, "R7 start ignored while busy");
    op(32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, 1'b1, "R10 back to back");
    op(32'h1, 32'hFFFFFFFF, 1'b0, 1'b1, "R10 back to back second");

    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 8 == 3) ra = ra | 32'hFFFF0000;
      if (i % 8 == 5) rb = 32'hFFFFFFFF;
      op(ra, rb, (i % 7 == 2), (i % 5 == 4), "R4 random product");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule